// File: doc/BRIEF.md
# Windowed Shared-Register Access Bridge

This block gives a host on a simple 32-bit register bus a way into a bank of shared internal registers through just two bus locations: a command window and a data window. The command window takes a 16-bit target offset and a 2-bit operation code. A write to the command window with a load or store code starts one transaction on the internal shared-register port. The data window holds the 32 bits that go out on a store, or the 32 bits that come back on a load.

The bridge needs no power-up or access-request step before use, so a host can reach the shared bank while other parts of the chip are unpowered. To store, the host fills the data window and then writes the command window. To load, the host writes the command window and, once the busy bit has cleared, reads the data window. A single grant input stands in for the arbiter of the internal port.

Top module: `shb_window_bridge`

## Requirements
- R1: The command window sits at bus address 0xEC and the data window at 0xF4. A read of any other address returns zero, and a write to any other address changes nothing.
- R2: While idle, a bus write to the data window stores all 32 bits, and a later read of the data window returns them.
- R3: A command write with bits [29:28] = 3 (store), made while idle, raises `sh_req` from the next cycle with `sh_we` = 1, `sh_offset` = command bits [15:0] and `sh_wdata` = the data window contents.
- R4: A command write with bits [29:28] = 2 (load), made while idle, raises `sh_req` from the next cycle with `sh_we` = 0 and `sh_offset` = command bits [15:0].
- R5: A command write with bits [29:28] equal to 0 or 1 is ignored. It raises no request and leaves the command readback unchanged.
- R6: `sh_req` and its offset stay steady until `sh_gnt` is sampled high, and `sh_req` is low in the cycle after that grant.
- R7: On the grant of a load, `sh_rdata` is captured into the data window.
- R8: Command readback shows busy in bit 31, the last accepted operation in bits [29:28] and the offset in bits [15:0], with zeros elsewhere. Busy is set from the cycle after the trigger until the grant edge.
- R9: While busy, command writes and data writes are dropped and leave the transaction in progress unchanged.
- R10: Reset clears the data window, the offset, the operation and busy, and leaves no request pending.
- R11: Bus read data is registered. It appears in the cycle after `bus_rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| sh_req | output | 1 | Request to the shared-register port |
| sh_we | output | 1 | Request is a store |
| sh_offset | output | 16 | Target shared-register offset |
| sh_wdata | output | 32 | Store data |
| sh_gnt | input | 1 | Arbiter grant, completes the request |
| sh_rdata | input | 32 | Load data, valid together with the grant |

## Verification
A wrong sequencing state shows up at the internal port within one cycle. It appears as a request that starts without a valid trigger, one that drops before its grant, one that stays up after its grant, or a wrong store flag or offset. A corrupted window shows up on the first bus read that follows, as a wrong busy bit, wrong operation or offset fields, or stale data in the data window. A reference model in the bench tracks the port outputs and the read data on every clock, so any such divergence is reported in the cycle where it first appears.

// File: rtl/shb_pkg.sv
package shb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE0 = 2'd0,
    OP_IDLE1 = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STORE = 2'd3
  } shb_op_e;

  localparam int OP_LSB   = 28;
  localparam int BUSY_BIT = 31;
endpackage

// File: rtl/shb_window_decode.sv
module shb_window_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hEC,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 8'hF4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_wr,
  output logic              dat_wr,
  output logic              cmd_rd,
  output logic              dat_rd,
  output logic              any_rd
);
  logic hit_cmd, hit_dat;

  always_comb begin
    hit_cmd = (addr == CMD_ADDR);
    hit_dat = (addr == DAT_ADDR);
    cmd_wr  = wr_en && hit_cmd;
    dat_wr  = wr_en && hit_dat;
    cmd_rd  = rd_en && hit_cmd;
    dat_rd  = rd_en && hit_dat;
    any_rd  = rd_en;
  end
endmodule

// File: rtl/shb_txn_engine.sv
module shb_txn_engine
  import shb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              gnt,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              req,
  output logic              we,
  output logic [OFS_W-1:0]  ofs,
  output shb_op_e           op,
  output logic [DATA_W-1:0] data
);
  shb_op_e           op_q, op_in;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q;
  logic              req_q;
  logic              start;

  always_comb begin
    op_in = shb_op_e'(wdata[OP_LSB +: 2]);
    start = cmd_wr && !req_q && op_in[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE0;
      ofs_q  <= '0;
      data_q <= '0;
      req_q  <= 1'b0;
    end else begin
      if (start) begin
        op_q  <= op_in;
        ofs_q <= wdata[OFS_W-1:0];
        req_q <= 1'b1;
      end else if (req_q && gnt) begin
        req_q <= 1'b0;
        if (op_q == OP_LOAD) data_q <= rdata_in;
      end
      if (dat_wr && !req_q) data_q <= wdata;
    end
  end

  assign req  = req_q;
  assign we   = (op_q == OP_STORE);
  assign ofs  = ofs_q;
  assign op   = op_q;
  assign data = data_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_q && !gnt |=> req_q && $stable(ofs_q) && $stable(op_q)); // R6
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    req_q && gnt |=> !req_q); // R6
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    req_q && gnt && op_q == OP_LOAD |=> data_q == $past(rdata_in)); // R7
  AST_IGNORE_IDLE_OP: assert property (@(posedge clk) disable iff (rst)
    !req_q && cmd_wr && !wdata[OP_LSB+1] |=> !req_q && $stable(ofs_q)); // R5
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    req_q && !gnt |=> $stable(data_q)); // R9
  AST_REQ_OP_VALID: assert property (@(posedge clk) disable iff (rst)
    req_q |-> op_q[1]); // R3
endmodule

// File: rtl/shb_readback.sv
module shb_readback
  import shb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rd,
  input  logic              dat_rd,
  input  logic              any_rd,
  input  logic              busy,
  input  shb_op_e           op,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cmd_word, sel;

  always_comb begin
    cmd_word                 = '0;
    cmd_word[BUSY_BIT]       = busy;
    cmd_word[OP_LSB +: 2]    = op;
    cmd_word[OFS_W-1:0]      = ofs;
    sel = '0;
    if (cmd_rd)      sel = cmd_word;
    else if (dat_rd) sel = data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (any_rd) rdata <= sel;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !any_rd |=> $stable(rdata)); // R11
endmodule

// File: rtl/shb_window_bridge.sv
module shb_window_bridge
  import shb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hEC,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 8'hF4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sh_req,
  output logic              sh_we,
  output logic [OFS_W-1:0]  sh_offset,
  output logic [DATA_W-1:0] sh_wdata,
  input  logic              sh_gnt,
  input  logic [DATA_W-1:0] sh_rdata
);
  logic              cmd_wr, dat_wr, cmd_rd, dat_rd, any_rd;
  logic              req;
  shb_op_e           op;
  logic [OFS_W-1:0]  ofs;
  logic [DATA_W-1:0] data;

  shb_window_decode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .DAT_ADDR(DAT_ADDR)) u_dec (
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
    .cmd_wr(cmd_wr), .dat_wr(dat_wr), .cmd_rd(cmd_rd), .dat_rd(dat_rd), .any_rd(any_rd)
  );

  shb_txn_engine #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_eng (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .wdata(bus_wdata),
    .gnt(sh_gnt), .rdata_in(sh_rdata), .req(req), .we(sh_we), .ofs(ofs),
    .op(op), .data(data)
  );

  shb_readback #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rb (
    .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .dat_rd(dat_rd), .any_rd(any_rd),
    .busy(req), .op(op), .ofs(ofs), .data(data), .rdata(bus_rdata)
  );

  assign sh_req    = req;
  assign sh_offset = ofs;
  assign sh_wdata  = data;

  AST_NO_REQ_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !sh_req); // R10
endmodule

// File: tb/test_shb_window_bridge.sv
module test_shb_window_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sh_req, sh_we, sh_gnt;
  logic [15:0] sh_offset;
  logic [31:0] sh_wdata, sh_rdata;

  int errors = 0, checks = 0;
  int gnt_delay = 2, wait_cnt = 0;
  bit done = 0;

  // reference model state
  bit          m_req;
  int          m_op;
  logic [15:0] m_ofs;
  logic [31:0] m_data, m_rdata;
  logic [31:0] bank [16];

  always #10 clk = ~clk;

  shb_window_bridge i_shb_window_bridge (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sh_req(sh_req), .sh_we(sh_we), .sh_offset(sh_offset), .sh_wdata(sh_wdata),
    .sh_gnt(sh_gnt), .sh_rdata(sh_rdata)
  );

  assign sh_rdata = bank[m_ofs[3:0]];

  initial begin
    for (int i = 0; i < 16; i++) bank[i] = 32'hA500_0000 + i * 17;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update at the clock edge
  always @(posedge clk) begin
    logic [31:0] cw;
    int nop;
    cw = {m_req, 1'b0, m_op[1:0], 12'h000, m_ofs};
    if (rst) begin
      m_req = 0; m_op = 0; m_ofs = '0; m_data = '0; m_rdata = '0;
    end else begin
      if (bus_rd_en)
        m_rdata = (bus_addr == 8'hEC) ? cw : (bus_addr == 8'hF4) ? m_data : 32'h0;
      nop = int'(bus_wdata[29:28]);
      if (m_req && sh_gnt) begin
        if (m_op == 3) bank[m_ofs[3:0]] = m_data;
        else m_data = sh_rdata;
        m_req = 0;
      end else if (!m_req) begin
        if (bus_wr_en && bus_addr == 8'hF4) m_data = bus_wdata;
        if (bus_wr_en && bus_addr == 8'hEC && nop >= 2) begin
          m_req = 1; m_op = nop; m_ofs = bus_wdata[15:0];
        end
      end
    end
  end

  // compare every cycle, then decide the grant
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3/R6 sh_req", {31'b0, sh_req}, {31'b0, m_req});
      chk("R11 bus_rdata", bus_rdata, m_rdata);
      if (m_req) begin
        chk("R3/R4 sh_we", {31'b0, sh_we}, {31'b0, m_op == 3});
        chk("R3 sh_offset", {16'h0, sh_offset}, {16'h0, m_ofs});
        if (m_op == 3) chk("R3 sh_wdata", sh_wdata, m_data);
      end
    end
    if (m_req && !sh_gnt) wait_cnt++; else wait_cnt = 0;
    sh_gnt = m_req && (wait_cnt >= gnt_delay) && !sh_gnt;
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_en = 1; bus_addr = a;
    @(negedge clk); bus_rd_en = 0; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    sh_gnt = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 sh_req after reset", {31'b0, sh_req}, 32'h0);
    rd(8'hEC, v); chk("R10 cmd readback", v, 32'h0);
    rd(8'hF4, v); chk("R10 data readback", v, 32'h0);
    // R1 unmapped
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, v); chk("R1 unmapped read", v, 32'h0);
    // R2 data window
    wr(8'hF4, 32'hDEAD_BEEF);
    rd(8'hF4, v); chk("R2 data readback", v, 32'hDEAD_BEEF);
    // R3 store to offset 9
    wr(8'hEC, 32'h3000_0009);
    idle(6);
    chk("R3 bank store", bank[9], 32'hDEAD_BEEF);
    // R4/R7/R8 load offset 3 with long grant delay
    gnt_delay = 8;
    wr(8'hEC, 32'h2000_0003);
    rd(8'hEC, v); chk("R8 busy readback", v, 32'hA000_0003);
    // R9 drops while busy
    wr(8'hEC, 32'h3000_0005);
    wr(8'hF4, 32'h1111_2222);
    rd(8'hEC, v); chk("R9 cmd unchanged while busy", v, 32'hA000_0003);
    idle(10);
    rd(8'hEC, v); chk("R8 busy cleared", v, 32'h2000_0003);
    rd(8'hF4, v); chk("R7 load captured", v, 32'hA500_0000 + 3 * 17);
    // R5 ignored codes
    gnt_delay = 0;
    wr(8'hEC, 32'h1000_0007);
    chk("R5 no request op1", {31'b0, sh_req}, 32'h0);
    wr(8'hEC, 32'h0000_0008);
    rd(8'hEC, v); chk("R5 cmd unchanged", v, 32'h2000_0003);
    // store then load back with immediate grant
    wr(8'hF4, 32'h0BAD_F00D);
    wr(8'hEC, 32'h3000_000C);
    idle(3);
    wr(8'hF4, 32'h0);
    wr(8'hEC, 32'h2000_000C);
    idle(3);
    rd(8'hF4, v); chk("R4/R7 load after store", v, 32'h0BAD_F00D);
    // R10 reset mid-transaction
    gnt_delay = 20;
    wr(8'hEC, 32'h2000_0001);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10 request cleared", {31'b0, sh_req}, 32'h0);
    rd(8'hEC, v); chk("R10 cmd after reset", v, 32'h0);
    idle(4);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule